// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps track of loads that the compiler hoisted above stores that might write the same bytes. When such a hoisted load executes, it records an entry keyed by the register it wrote, together with the byte address and access size it read. Every store that executes later is compared against all live entries at once. Any entry whose byte range the store touches is dropped, because the hoisted value may now be stale.

When the program reaches the original position of the load, it issues a check on the same register. If the entry is still live, the speculation held and the register value may be used. If the entry is gone, the response tells the caller what to do. The check carries a failure mode that selects one of two actions: redo the load, or branch to recovery code. A check can also ask for its entry to be released on a hit. A flush input empties the table, for example on a context switch.

Top module: `spec_load_table`

## Requirements
- R1: After a load on `ld_en` with register `ld_reg`, a check on that register in any later cycle reports a hit, provided nothing has removed the entry in between.
- R2: Each register owns at most one entry. A new load to a register that already has an entry replaces that entry's address and size, so a store to the old address no longer removes it.
- R3: A load for a register with no entry takes the lowest-numbered empty slot. When all 8 slots are full, it replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and moves on by one (wrapping from 7 to 0) only when such a replacement happens.
- R4: A store removes every live entry whose byte range overlaps its own. Each range is [addr, addr + 2^size), with size codes 0, 1, 2 and 3 meaning 1, 2, 4 and 8 bytes. Ranges that only touch at an edge do not overlap. Ranges do not wrap past the top of the 32-bit address space.
- R5: A check is answered in the cycle after `chk_en`, with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_reload` and `rsp_branch` high. On a miss, `chk_mode` 0 selects `rsp_reload` and 1 selects `rsp_branch`. When `rsp_valid` is low, all three are low.
- R6: When a store and a check occur in the same cycle and the store overlaps the checked entry, the store acts first: the check misses and the entry is removed.
- R7: A check with `chk_clear`=1 that hits removes its entry. A check with `chk_clear`=0 that hits leaves the entry live.
- R8: `flush` removes every entry, including one being loaded in the same cycle.
- R9: After reset the table is empty and all response outputs are low.
- R10: A load that occurs in the same cycle as a store overlapping it still leaves a live entry, because the load is recorded after the store has been compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole table |
| ld_en | input | 1 | A hoisted load executed this cycle |
| ld_reg | input | 7 | Destination register of the load |
| ld_addr | input | 32 | Byte address read by the load |
| ld_size | input | 2 | Load size code (1, 2, 4 or 8 bytes) |
| st_en | input | 1 | A store executed this cycle |
| st_addr | input | 32 | Byte address written by the store |
| st_size | input | 2 | Store size code |
| chk_en | input | 1 | Check request |
| chk_reg | input | 7 | Register being checked |
| chk_clear | input | 1 | Remove the entry if the check hits |
| chk_mode | input | 1 | Miss action: 0 reload, 1 branch to recovery |
| rsp_valid | output | 1 | Check response present |
| rsp_hit | output | 1 | Speculation held |
| rsp_reload | output | 1 | Speculation failed, redo the load |
| rsp_branch | output | 1 | Speculation failed, branch to recovery |

## Verification
The bench runs every pairing of entry size and store size against store addresses that slide across the entry from well before it to well after it. A design with off-by-one range ends would either remove entries that a store only touches at an edge or keep entries that a store partly covers. It fills the table and overflows it, including a case where a slot is freed midway, to catch a pointer that moves on free-slot allocations or a design that replaces a slot while an empty one exists. It also applies stores, checks, loads and flushes in the same cycle, where a wrong priority lets stale speculation pass or discards a fresh load. A separate case stores near the top of the address space to catch an address sum that wraps.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned REG_W  = 7;
  localparam int unsigned ADDR_W = 32;

  typedef logic [REG_W-1:0]  reg_id_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic      live;
    reg_id_t   owner;
    addr_t     base;
    logic [1:0] szc;
  } slot_t;

  typedef enum logic {MISS_RELOAD = 1'b0, MISS_BRANCH = 1'b1} miss_mode_e;

  // One past the last byte, kept one bit wider so it never wraps.
  function automatic logic [ADDR_W:0] range_limit(addr_t a, logic [1:0] szc);
    logic [ADDR_W:0] span;
    span = '0;
    span[szc] = 1'b1;
    return {1'b0, a} + span;
  endfunction

  function automatic logic ranges_meet(addr_t a, logic [1:0] sa, addr_t b, logic [1:0] sb);
    return ({1'b0, a} < range_limit(b, sb)) && ({1'b0, b} < range_limit(a, sa));
  endfunction
endpackage

// File: rtl/slt_lookup.sv
module slt_lookup
  import slt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  slot_t [ENTRIES-1:0] slots,
  input  reg_id_t             ld_reg,
  input  reg_id_t             chk_reg,
  input  addr_t               st_addr,
  input  logic [1:0]          st_size,
  output logic [ENTRIES-1:0]  own_vec,
  output logic [ENTRIES-1:0]  chk_vec,
  output logic [ENTRIES-1:0]  kill_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign own_vec[g]  = slots[g].live && (slots[g].owner == ld_reg);
    assign chk_vec[g]  = slots[g].live && (slots[g].owner == chk_reg);
    assign kill_vec[g] = slots[g].live &&
                         ranges_meet(slots[g].base, slots[g].szc, st_addr, st_size);
  end
endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
  parameter  int ENTRIES = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_fire,
  input  logic [ENTRIES-1:0] live_vec,
  input  logic [ENTRIES-1:0] own_vec,
  output logic [IDX_W-1:0]   slot_idx
);
  logic [IDX_W-1:0] rr_ptr;
  logic             evict;
  logic             found;

  always_comb begin
    found    = 1'b0;
    slot_idx = rr_ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && own_vec[i]) begin
        slot_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !live_vec[i]) begin
        slot_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    evict = !found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (ld_fire && evict) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_NO_EVICT_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && !(&live_vec) |-> (!live_vec[slot_idx] || own_vec[slot_idx])); // R3
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire && ((|own_vec) || !(&live_vec)) |=> $stable(rr_ptr)); // R3
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter  int ENTRIES = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_en,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_en,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  input  logic              chk_mode,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_reload,
  output logic              rsp_branch
);
  slot_t [ENTRIES-1:0] slots_q, slots_d;
  logic [ENTRIES-1:0]  live_vec, own_vec, chk_vec, kill_vec, chk_live_vec, st_drop_vec;
  logic [IDX_W-1:0]    slot_idx;
  logic                chk_hit_now;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign live_vec[g] = slots_q[g].live;
  end

  slt_lookup #(.ENTRIES(ENTRIES)) u_lookup (
    .slots   (slots_q),
    .ld_reg  (ld_reg),
    .chk_reg (chk_reg),
    .st_addr (st_addr),
    .st_size (st_size),
    .own_vec (own_vec),
    .chk_vec (chk_vec),
    .kill_vec(kill_vec)
  );

  slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_fire (ld_en),
    .live_vec(live_vec),
    .own_vec (own_vec),
    .slot_idx(slot_idx)
  );

  // Store is applied before the check looks at the table.
  assign st_drop_vec  = st_en ? kill_vec : '0;
  assign chk_live_vec = chk_vec & ~st_drop_vec;
  assign chk_hit_now  = |chk_live_vec;

  // Order inside one cycle: store, clearing check, load, then flush.
  always_comb begin
    slots_d = slots_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st_drop_vec[i]) slots_d[i].live = 1'b0;
      if (chk_en && chk_clear && chk_live_vec[i]) slots_d[i].live = 1'b0;
      if (ld_en && (slot_idx == IDX_W'(i))) begin
        slots_d[i].live  = 1'b1;
        slots_d[i].owner = ld_reg;
        slots_d[i].base  = ld_addr;
        slots_d[i].szc   = ld_size;
      end
      if (flush) slots_d[i].live = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_reload <= 1'b0;
      rsp_branch <= 1'b0;
    end else begin
      slots_q    <= slots_d;
      rsp_valid  <= chk_en;
      rsp_hit    <= chk_en && chk_hit_now;
      rsp_reload <= chk_en && !chk_hit_now && (miss_mode_e'(chk_mode) == MISS_RELOAD);
      rsp_branch <= chk_en && !chk_hit_now && (miss_mode_e'(chk_mode) == MISS_BRANCH);
    end
  end

  AST_ONE_SLOT_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_vec)); // R2
  AST_STORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    st_en && !ld_en |=> ((live_vec & $past(kill_vec)) == '0)); // R4
  AST_RSP_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_reload, rsp_branch})); // R5
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_reload, rsp_branch} == 3'b000)); // R5
  AST_STORE_BEATS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && st_en && ((chk_vec & kill_vec) != '0) |=> rsp_valid && !rsp_hit); // R6
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && chk_clear && chk_hit_now && !ld_en |=> ((live_vec & $past(chk_live_vec)) == '0)); // R7
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !chk_clear && chk_hit_now && !st_en && !flush |=> ((live_vec & $past(chk_live_vec)) != '0)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_vec == '0)); // R8
  AST_LOAD_SURVIVES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !flush |=> live_vec[$past(slot_idx)]); // R10
endmodule

// File: tb/spec_load_table_test.sv
`timescale 1ns/1ps
module spec_load_table_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, ld_en, st_en, chk_en, chk_clear, chk_mode;
  logic [6:0]  ld_reg, chk_reg;
  logic [31:0] ld_addr, st_addr;
  logic [1:0]  ld_size, st_size;
  logic        rsp_valid, rsp_hit, rsp_reload, rsp_branch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spec_load_table uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_en(st_en), .st_addr(st_addr), .st_size(st_size),
    .chk_en(chk_en), .chk_reg(chk_reg), .chk_clear(chk_clear), .chk_mode(chk_mode),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reload(rsp_reload), .rsp_branch(rsp_branch)
  );

  task automatic quiet();
    flush = 0; ld_en = 0; st_en = 0; chk_en = 0; chk_clear = 0; chk_mode = 0;
    ld_reg = 0; chk_reg = 0; ld_addr = 0; st_addr = 0; ld_size = 0; st_size = 0;
  endtask

  // Apply one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic step();
    @(negedge clk);
    quiet();
  endtask

  task automatic do_load(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
    ld_en = 1; ld_reg = r; ld_addr = a; ld_size = s;
    step();
  endtask

  task automatic do_store(input logic [31:0] a, input logic [1:0] s);
    st_en = 1; st_addr = a; st_size = s;
    step();
  endtask

  task automatic do_flush();
    flush = 1;
    step();
  endtask

  task automatic judge(input bit exp_hit, input bit mode, input string req);
    logic [3:0] act, exp;
    act = {rsp_valid, rsp_hit, rsp_reload, rsp_branch};
    exp = {1'b1, exp_hit, !exp_hit && !mode, !exp_hit && mode};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rsp v/h/r/b actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic probe(input logic [6:0] r, input bit clr, input bit mode,
                       input bit exp_hit, input string req);
    chk_en = 1; chk_reg = r; chk_clear = clr; chk_mode = mode;
    step();
    judge(exp_hit, mode, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state
    checks++;
    if ({rsp_valid, rsp_hit, rsp_reload, rsp_branch} !== 4'b0) begin
      fails++;
      $display("FAIL R9: outputs actual %b expected 0000", {rsp_valid, rsp_hit, rsp_reload, rsp_branch});
    end
    probe(7'd5, 0, 0, 0, "R9 empty reload");
    probe(7'd5, 0, 1, 0, "R5 empty branch");

    // R1 / R7 non-clearing then clearing
    do_load(7'd3, 32'h40, 2'd2);
    probe(7'd3, 0, 0, 1, "R1 hit");
    probe(7'd3, 0, 1, 1, "R7 peek keeps");
    probe(7'd3, 1, 0, 1, "R7 clear hit");
    probe(7'd3, 0, 1, 0, "R7 cleared");

    // R4 sweep over sizes and positions
    for (int se = 0; se < 4; se++) begin
      for (int ss = 0; ss < 4; ss++) begin
        for (int off = -12; off < 12; off++) begin
          longint unsigned e_lo, e_hi, s_lo, s_hi, lo, hi;
          bit meet;
          e_lo = 64'h100; e_hi = e_lo + (64'd1 << se);
          s_lo = 64'(64'sh100 + off); s_hi = s_lo + (64'd1 << ss);
          lo = (e_lo > s_lo) ? e_lo : s_lo;
          hi = (e_hi < s_hi) ? e_hi : s_hi;
          meet = lo < hi;
          do_flush();
          do_load(7'd1, 32'h100, 2'(se));
          do_store(32'(s_lo), 2'(ss));
          probe(7'd1, 1, 0, !meet, "R4 sweep");
        end
      end
    end

    // R4 no wrap at top of address space
    do_flush();
    do_load(7'd60, 32'hFFFF_FFFC, 2'd2);
    do_store(32'h0, 2'd3);
    probe(7'd60, 0, 0, 1, "R4 no wrap");

    // R2 one entry per register
    do_load(7'd9, 32'h200, 2'd0);
    do_load(7'd9, 32'h300, 2'd0);
    do_store(32'h200, 2'd0);
    probe(7'd9, 0, 0, 1, "R2 old address ignored");
    do_store(32'h300, 2'd0);
    probe(7'd9, 0, 1, 0, "R2 new address tracked");

    // R3 fill, overflow, free-slot reuse
    do_flush();
    for (int i = 0; i < 8; i++) do_load(7'(10 + i), 32'(32'h1000 + i * 16), 2'd0);
    do_load(7'd20, 32'h2000, 2'd0);
    probe(7'd10, 0, 1, 0, "R3 first victim");
    for (int i = 1; i < 8; i++) probe(7'(10 + i), 0, 0, 1, "R3 others kept");
    probe(7'd20, 0, 0, 1, "R3 newcomer");
    do_load(7'd21, 32'h2010, 2'd0);
    probe(7'd11, 0, 0, 0, "R3 second victim");
    probe(7'd14, 1, 0, 1, "R3 free slot 4");
    do_load(7'd22, 32'h2020, 2'd0);
    do_load(7'd23, 32'h2030, 2'd0);
    probe(7'd12, 0, 1, 0, "R3 pointer held on free fill");
    probe(7'd13, 0, 0, 1, "R3 slot 3 kept");
    probe(7'd22, 0, 0, 1, "R3 free slot used");
    probe(7'd23, 0, 0, 1, "R3 latest");

    // R6 store and check in one cycle
    do_flush();
    do_load(7'd30, 32'h500, 2'd3);
    st_en = 1; st_addr = 32'h508; st_size = 2'd0;
    chk_en = 1; chk_reg = 7'd30; chk_mode = 0;
    step();
    judge(1, 0, "R6 disjoint store");
    st_en = 1; st_addr = 32'h504; st_size = 2'd0;
    chk_en = 1; chk_reg = 7'd30; chk_mode = 1;
    step();
    judge(0, 1, "R6 same-cycle store wins");
    probe(7'd30, 0, 0, 0, "R6 entry gone");

    // R8 flush with concurrent load
    do_load(7'd40, 32'h700, 2'd1);
    flush = 1; ld_en = 1; ld_reg = 7'd41; ld_addr = 32'h800; ld_size = 2'd1;
    step();
    probe(7'd40, 0, 0, 0, "R8 old dropped");
    probe(7'd41, 0, 1, 0, "R8 concurrent load dropped");

    // R10 load alongside overlapping store
    ld_en = 1; ld_reg = 7'd50; ld_addr = 32'h600; ld_size = 2'd2;
    st_en = 1; st_addr = 32'h600; st_size = 2'd2;
    step();
    probe(7'd50, 0, 0, 1, "R10 load kept");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule